// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits on a 16-bit address, 8-bit data processor bus and steers every access to one of several backing stores: a startup ROM overlay, a fixed ROM window, a switchable ROM window, switchable cartridge RAM, two 4 KiB work RAMs, a video/object window, an I/O window, a small high RAM and a one-byte interrupt-enable register held inside the block. For each address it reports a region code and the translated physical address for every store. The selected store's read byte comes back on `mem_rdata` and is forwarded to the processor, except where the block itself supplies the byte.

Writes that land in ROM space never reach a store. They are taken as commands instead. One range gates the cartridge RAM with a key byte. A second range loads the ROM bank, keeping 7 bits and turning a zero bank into bank 1. A third range loads a 2-bit RAM bank. The startup overlay covers the lowest addresses but leaves a hole at 0x100–0x1FF. A one-way control input turns the overlay off until the next reset.

Top module: `mmap_bank_decoder`

## Requirements
- R1: While `rst` is high, and from then until the first command, the ROM bank is 1, the RAM bank is 0, cartridge RAM is disabled, the startup overlay is active and the interrupt-enable byte is 0x00.
- R2: `region` takes these codes: 0 unmapped, 1 startup ROM, 2 fixed ROM (0x0000–0x3FFF), 3 switchable ROM (0x4000–0x7FFF), 4 cartridge RAM (0xA000–0xBFFF), 5 work RAM low (0xC000–0xCFFF), 6 work RAM high (0xD000–0xDFFF), 7 video (0x8000–0x9FFF and 0xFE00–0xFE9F), 8 I/O (0xFF00–0xFF7F), 9 high RAM (0xFF80–0xFFFE), 10 interrupt-enable (0xFFFF). Everything else is code 0.
- R3: While the overlay is active, addresses 0x0000–0x00FF and 0x0200–0x08FF give code 1 with `boot_addr` equal to address bits 11:0. Addresses 0x0100–0x01FF still give code 2.
- R4: A cycle with `boot_done` high clears the overlay. It then stays cleared until reset, and the low addresses decode as fixed ROM.
- R5: A write below 0x2000 enables cartridge RAM when the data is 0x0A and disables it for any other value.
- R6: A write in 0x2000–0x3FFF sets the ROM bank to data bits 6:0. A masked value of 0 selects bank 1, so the bank is never 0.
- R7: A write in 0x4000–0x5FFF sets the RAM bank to data bits 1:0. Writes in 0x6000–0x7FFF change nothing.
- R8: `rom_addr` (21 bits) is {7'b0, addr[13:0]} for fixed ROM and {bank, addr[13:0]} for switchable ROM.
- R9: `xram_addr` is {ram bank, addr[12:0]}. While cartridge RAM is disabled, a read there returns 0xFF and a write raises no `store_we`.
- R10: `wram_addr` is addr[11:0] for both work-RAM halves, and `hram_addr` is addr[6:0].
- R11: `vid_addr` is the address with bit 15 cleared, and `io_idx` is the low address byte.
- R12: A write to 0xFFFF stores the data in the interrupt-enable byte, and a read of 0xFFFF returns that byte.
- R13: An unmapped address reads 0x00. `store_we` follows `bus_wr` only in regions 4 (when enabled) through 9, and never in ROM space, unmapped space or 0xFFFF.
- R14: In the startup ROM, ROM, enabled cartridge RAM, work RAM, video, I/O and high-RAM regions, `bus_rdata` equals `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Processor write data |
| bus_wr | input | 1 | Write strobe for the current address |
| boot_done | input | 1 | Turns the startup overlay off |
| mem_rdata | input | 8 | Read byte from the selected backing store |
| bus_rdata | output | 8 | Read byte returned to the processor |
| region | output | 4 | Region code (R2) |
| store_we | output | 1 | Write strobe to the selected backing store |
| boot_addr | output | 12 | Startup ROM address |
| rom_addr | output | 21 | Physical ROM address |
| xram_addr | output | 15 | Physical cartridge RAM address |
| wram_addr | output | 12 | Work RAM offset |
| vid_addr | output | 16 | Video window address, bit 15 cleared |
| io_idx | output | 8 | I/O register index |
| hram_addr | output | 7 | High RAM offset |

## Verification
All outputs are combinational from the address and the command registers. A wrong bank, enable or overlay flag therefore shows on the very next access to the affected window, one clock after the command write. A stale ROM bank shows in the upper bits of `rom_addr` at any 0x4000–0x7FFF address. A wrong enable flag shows as a spurious 0xFF, or as a missing or extra `store_we`, in 0xA000–0xBFFF. A wrong overlay flag moves the low addresses between region codes 1 and 2. The random mix interleaves command writes with reads in every window, so a corrupted register is seen within a few accesses.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 8;
    localparam int ROM_BANK_W  = 7;
    localparam int RAM_BANK_W  = 2;
    localparam int ROM_OFS_W   = 14;
    localparam int RAM_OFS_W   = 13;
    localparam int WRAM_OFS_W  = 12;
    localparam int BOOT_W      = 12;
    localparam int HRAM_W      = 7;
    localparam int IO_W        = 8;
    localparam int ROM_ADDR_W  = ROM_BANK_W + ROM_OFS_W;
    localparam int XRAM_ADDR_W = RAM_BANK_W + RAM_OFS_W;

    localparam logic [DATA_W-1:0] RAM_KEY      = 8'h0A;
    localparam logic [DATA_W-1:0] XRAM_OFF_VAL = 8'hFF;
    localparam logic [DATA_W-1:0] UNMAPPED_VAL = 8'h00;

    typedef enum logic [3:0] {
        RG_NONE  = 4'd0,
        RG_BOOT  = 4'd1,
        RG_ROM0  = 4'd2,
        RG_ROMX  = 4'd3,
        RG_XRAM  = 4'd4,
        RG_WRAM0 = 4'd5,
        RG_WRAM1 = 4'd6,
        RG_VIDEO = 4'd7,
        RG_IO    = 4'd8,
        RG_HRAM  = 4'd9,
        RG_IE    = 4'd10
    } region_e;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_RAM_EN  = 2'd1,
        CMD_ROMBANK = 2'd2,
        CMD_RAMBANK = 2'd3
    } cmd_e;

    typedef struct packed {
        logic [ROM_BANK_W-1:0] rom_bank;
        logic [RAM_BANK_W-1:0] ram_bank;
        logic                  ram_en;
        logic                  boot_on;
        logic [DATA_W-1:0]     ie;
    } ctrl_t;

    function automatic region_e decode_region(input logic [ADDR_W-1:0] a,
                                              input logic boot_on);
        region_e r;
        if (boot_on && (a < 16'h0100 || (a >= 16'h0200 && a < 16'h0900)))
            r = RG_BOOT;
        else if (a < 16'h4000)                   r = RG_ROM0;
        else if (a < 16'h8000)                   r = RG_ROMX;
        else if (a < 16'hA000)                   r = RG_VIDEO;
        else if (a < 16'hC000)                   r = RG_XRAM;
        else if (a < 16'hD000)                   r = RG_WRAM0;
        else if (a < 16'hE000)                   r = RG_WRAM1;
        else if (a >= 16'hFE00 && a < 16'hFEA0)  r = RG_VIDEO;
        else if (a >= 16'hFF00 && a < 16'hFF80)  r = RG_IO;
        else if (a >= 16'hFF80 && a < 16'hFFFF)  r = RG_HRAM;
        else if (a == 16'hFFFF)                  r = RG_IE;
        else                                     r = RG_NONE;
        return r;
    endfunction

    function automatic cmd_e decode_cmd(input logic [ADDR_W-1:0] a);
        unique case (a[15:13])
            3'b000:  return CMD_RAM_EN;
            3'b001:  return CMD_ROMBANK;
            3'b010:  return CMD_RAMBANK;
            default: return CMD_NONE;
        endcase
    endfunction

    function automatic logic [ROM_BANK_W-1:0] remap_bank(input logic [DATA_W-1:0] d);
        logic [ROM_BANK_W-1:0] m;
        m = d[ROM_BANK_W-1:0];
        return (m == '0) ? ROM_BANK_W'(1) : m;
    endfunction

    function automatic logic is_store_region(input region_e r);
        return (r == RG_WRAM0) || (r == RG_WRAM1) || (r == RG_VIDEO) ||
               (r == RG_IO)    || (r == RG_HRAM);
    endfunction

endpackage

// File: rtl/mmap_region_decode.sv
module mmap_region_decode
    import mmap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              boot_on,
    output region_e           region,
    output cmd_e              cmd
);
    always_comb begin
        region = decode_region(addr, boot_on);
        cmd    = decode_cmd(addr);
    end
endmodule

// File: rtl/mmap_bank_ctrl.sv
module mmap_bank_ctrl
    import mmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              boot_done,
    input  cmd_e              cmd,
    input  region_e           region,
    output ctrl_t             ctrl
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.rom_bank <= ROM_BANK_W'(1);
            ctrl_q.ram_bank <= '0;
            ctrl_q.ram_en   <= 1'b0;
            ctrl_q.boot_on  <= 1'b1;
            ctrl_q.ie       <= '0;
        end else begin
            if (boot_done)
                ctrl_q.boot_on <= 1'b0;
            if (bus_wr) begin
                unique case (cmd)
                    CMD_RAM_EN:  ctrl_q.ram_en   <= (bus_wdata == RAM_KEY);
                    CMD_ROMBANK: ctrl_q.rom_bank <= remap_bank(bus_wdata);
                    CMD_RAMBANK: ctrl_q.ram_bank <= bus_wdata[RAM_BANK_W-1:0];
                    default: ;
                endcase
                if (region == RG_IE)
                    ctrl_q.ie <= bus_wdata;
            end
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/mmap_xlate.sv
module mmap_xlate
    import mmap_pkg::*;
(
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   bus_wr,
    input  region_e                region,
    input  ctrl_t                  ctrl,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   store_we,
    output logic [BOOT_W-1:0]      boot_addr,
    output logic [ROM_ADDR_W-1:0]  rom_addr,
    output logic [XRAM_ADDR_W-1:0] xram_addr,
    output logic [WRAM_OFS_W-1:0]  wram_addr,
    output logic [ADDR_W-1:0]      vid_addr,
    output logic [IO_W-1:0]        io_idx,
    output logic [HRAM_W-1:0]      hram_addr
);
    logic [ROM_BANK_W-1:0] eff_bank;

    always_comb begin
        eff_bank  = (region == RG_ROMX) ? ctrl.rom_bank : '0;
        rom_addr  = {eff_bank, addr[ROM_OFS_W-1:0]};
        xram_addr = {ctrl.ram_bank, addr[RAM_OFS_W-1:0]};
        boot_addr = addr[BOOT_W-1:0];
        wram_addr = addr[WRAM_OFS_W-1:0];
        vid_addr  = {1'b0, addr[ADDR_W-2:0]};
        io_idx    = addr[IO_W-1:0];
        hram_addr = addr[HRAM_W-1:0];
    end

    always_comb begin
        unique case (region)
            RG_NONE: bus_rdata = UNMAPPED_VAL;
            RG_XRAM: bus_rdata = ctrl.ram_en ? mem_rdata : XRAM_OFF_VAL;
            RG_IE:   bus_rdata = ctrl.ie;
            default: bus_rdata = mem_rdata;
        endcase
    end

    always_comb begin
        store_we = bus_wr &&
                   (is_store_region(region) || (region == RG_XRAM && ctrl.ram_en));
    end
endmodule

// File: rtl/mmap_bank_decoder.sv
module mmap_bank_decoder
    import mmap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_wr,
    input  logic        boot_done,
    input  logic [7:0]  mem_rdata,
    output logic [7:0]  bus_rdata,
    output logic [3:0]  region,
    output logic        store_we,
    output logic [11:0] boot_addr,
    output logic [20:0] rom_addr,
    output logic [14:0] xram_addr,
    output logic [11:0] wram_addr,
    output logic [15:0] vid_addr,
    output logic [7:0]  io_idx,
    output logic [6:0]  hram_addr
);
    region_e region_w;
    cmd_e    cmd_w;
    ctrl_t   ctrl_w;

    logic [ROM_BANK_W-1:0] rom_bank;
    logic [RAM_BANK_W-1:0] ram_bank;
    logic                  ram_en;
    logic                  boot_on;

    assign rom_bank = ctrl_w.rom_bank;
    assign ram_bank = ctrl_w.ram_bank;
    assign ram_en   = ctrl_w.ram_en;
    assign boot_on  = ctrl_w.boot_on;
    assign region   = region_w;

    mmap_region_decode u_dec (
        .addr    (bus_addr),
        .boot_on (boot_on),
        .region  (region_w),
        .cmd     (cmd_w)
    );

    mmap_bank_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .boot_done (boot_done),
        .cmd       (cmd_w),
        .region    (region_w),
        .ctrl      (ctrl_w)
    );

    mmap_xlate u_xlate (
        .addr      (bus_addr),
        .bus_wr    (bus_wr),
        .region    (region_w),
        .ctrl      (ctrl_w),
        .mem_rdata (mem_rdata),
        .bus_rdata (bus_rdata),
        .store_we  (store_we),
        .boot_addr (boot_addr),
        .rom_addr  (rom_addr),
        .xram_addr (xram_addr),
        .wram_addr (wram_addr),
        .vid_addr  (vid_addr),
        .io_idx    (io_idx),
        .hram_addr (hram_addr)
    );
endmodule

// File: rtl/mmap_bank_decoder_chk.sv
module mmap_bank_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_wr,
    input logic [3:0]  region,
    input logic        store_we,
    input logic [7:0]  bus_rdata,
    input logic [20:0] rom_addr,
    input logic [6:0]  rom_bank,
    input logic [1:0]  ram_bank,
    input logic        ram_en,
    input logic        boot_on
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rom_bank == 7'd1 && ram_bank == 2'd0 && !ram_en && boot_on)); // R1

    AST_BOOT_STICKY: assert property (@(posedge clk) disable iff (rst)
        !boot_on |=> !boot_on); // R4

    AST_RAMEN_KEY: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr < 16'h2000) |=> (ram_en == ($past(bus_wdata) == 8'h0A))); // R5

    AST_ROMBANK_NONZERO: assert property (@(posedge clk) disable iff (rst)
        rom_bank != 7'd0); // R6

    AST_RAMBANK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr >= 16'h4000 && bus_addr < 16'h6000)
        |=> (ram_bank == $past(bus_wdata[1:0]))); // R7

    AST_ROMX_XLATE: assert property (@(posedge clk) disable iff (rst)
        (region == 4'd3) |-> (rom_addr == {rom_bank, bus_addr[13:0]})); // R8

    AST_XRAM_OFF_READ: assert property (@(posedge clk) disable iff (rst)
        (region == 4'd4 && !ram_en) |-> (bus_rdata == 8'hFF && !store_we)); // R9

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (region == 4'd0) |-> (bus_rdata == 8'h00 && !store_we)); // R13

    AST_ROMSPACE_NO_WE: assert property (@(posedge clk) disable iff (rst)
        (bus_addr < 16'h8000) |-> !store_we); // R13
endmodule

bind mmap_bank_decoder mmap_bank_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .region    (region),
    .store_we  (store_we),
    .bus_rdata (bus_rdata),
    .rom_addr  (rom_addr),
    .rom_bank  (rom_bank),
    .ram_bank  (ram_bank),
    .ram_en    (ram_en),
    .boot_on   (boot_on)
);

// File: tb/mmap_bank_decoder_tb.sv
module mmap_bank_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        boot_done = 1'b0;
    logic [7:0]  mem_rdata;
    logic [7:0]  bus_rdata;
    logic [3:0]  region;
    logic        store_we;
    logic [11:0] boot_addr;
    logic [20:0] rom_addr;
    logic [14:0] xram_addr;
    logic [11:0] wram_addr;
    logic [15:0] vid_addr;
    logic [7:0]  io_idx;
    logic [6:0]  hram_addr;

    int checks = 0;
    int fails  = 0;

    // Reference state
    logic [6:0] m_bank;
    logic [1:0] m_rbank;
    logic       m_en;
    logic       m_boot;
    logic [7:0] m_ie;

    always #10 clk = ~clk;

    assign mem_rdata = bus_addr[7:0] ^ bus_addr[15:8] ^ 8'h5A;

    mmap_bank_decoder u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .boot_done(boot_done), .mem_rdata(mem_rdata),
        .bus_rdata(bus_rdata), .region(region), .store_we(store_we),
        .boot_addr(boot_addr), .rom_addr(rom_addr), .xram_addr(xram_addr),
        .wram_addr(wram_addr), .vid_addr(vid_addr), .io_idx(io_idx),
        .hram_addr(hram_addr)
    );

    function automatic int exp_region(input logic [15:0] a, input logic boot);
        if (boot && (a < 16'h0100 || (a >= 16'h0200 && a < 16'h0900))) return 1;
        if (a < 16'h4000) return 2;
        if (a < 16'h8000) return 3;
        if (a < 16'hA000) return 7;
        if (a < 16'hC000) return 4;
        if (a < 16'hD000) return 5;
        if (a < 16'hE000) return 6;
        if (a >= 16'hFE00 && a < 16'hFEA0) return 7;
        if (a >= 16'hFF00 && a < 16'hFF80) return 8;
        if (a >= 16'hFF80 && a < 16'hFFFF) return 9;
        if (a == 16'hFFFF) return 10;
        return 0;
    endfunction

    function automatic logic [7:0] exp_rdata(input int r, input logic [15:0] a);
        logic [7:0] mem;
        mem = a[7:0] ^ a[15:8] ^ 8'h5A;
        if (r == 0) return 8'h00;
        if (r == 4) return m_en ? mem : 8'hFF;
        if (r == 10) return m_ie;
        return mem;
    endfunction

    function automatic logic exp_we(input int r, input logic wr);
        return wr && ((r >= 5 && r <= 9) || (r == 4 && m_en));
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s addr=%h actual=%h expected=%h", req, what, bus_addr, act, exp);
        end
    endtask

    task automatic check_all();
        int r;
        r = exp_region(bus_addr, m_boot);
        chk("R2", "region", 32'(region), 32'(r));
        chk("R14", "bus_rdata", 32'(bus_rdata), 32'(exp_rdata(r, bus_addr)));
        chk("R13", "store_we", 32'(store_we), 32'(exp_we(r, bus_wr)));
        case (r)
            1: chk("R3", "boot_addr", 32'(boot_addr), 32'(bus_addr[11:0]));
            2: chk("R8", "rom_addr", 32'(rom_addr), {11'd0, 7'd0, bus_addr[13:0]});
            3: chk("R8", "rom_addr", 32'(rom_addr), {11'd0, m_bank, bus_addr[13:0]});
            4: chk("R9", "xram_addr", 32'(xram_addr), {17'd0, m_rbank, bus_addr[12:0]});
            5, 6: chk("R10", "wram_addr", 32'(wram_addr), 32'(bus_addr[11:0]));
            7: chk("R11", "vid_addr", 32'(vid_addr), 32'(bus_addr & 16'h7FFF));
            8: chk("R11", "io_idx", 32'(io_idx), 32'(bus_addr[7:0]));
            9: chk("R10", "hram_addr", 32'(hram_addr), 32'(bus_addr[6:0]));
            default: ;
        endcase
    endtask

    // One bus cycle: drive at negedge, check, then update the model after posedge.
    task automatic cycle(input logic [15:0] a, input logic [7:0] d,
                         input logic wr, input logic bd, input logic do_chk);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = wr; boot_done = bd;
        #2;
        if (do_chk) check_all();
        @(posedge clk);
        #1;
        if (bd) m_boot = 1'b0;
        if (wr) begin
            if (a < 16'h2000) m_en = (d == 8'h0A);
            else if (a < 16'h4000) m_bank = (d[6:0] == 7'd0) ? 7'd1 : d[6:0];
            else if (a < 16'h6000) m_rbank = d[1:0];
            else if (a == 16'hFFFF) m_ie = d;
        end
        bus_wr = 1'b0; boot_done = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a);
        cycle(a, 8'h00, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        cycle(a, d, 1'b1, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] a;
        logic [7:0]  d;
        void'($urandom(32'd20240829));
        m_bank = 7'd1; m_rbank = 2'd0; m_en = 1'b0; m_boot = 1'b1; m_ie = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state seen through the ports
        rd(16'h4123);
        chk("R1", "rom bank after reset", 32'(rom_addr[20:14]), 32'd1);
        rd(16'hA010);
        chk("R1", "xram disabled after reset", 32'(bus_rdata), 32'hFF);
        chk("R1", "ram bank after reset", 32'(xram_addr[14:13]), 32'd0);
        rd(16'h0050);
        chk("R1", "overlay active after reset", 32'(region), 32'd1);
        rd(16'hFFFF);
        chk("R1", "ie after reset", 32'(bus_rdata), 32'h00);

        // R3: overlay edges and hole
        rd(16'h00FF); chk("R3", "0x00FF boot", 32'(region), 32'd1);
        rd(16'h0100); chk("R3", "0x0100 hole", 32'(region), 32'd2);
        rd(16'h01FF); chk("R3", "0x01FF hole", 32'(region), 32'd2);
        rd(16'h08FF); chk("R3", "0x08FF boot", 32'(region), 32'd1);
        rd(16'h0900); chk("R3", "0x0900 rom", 32'(region), 32'd2);

        // R6: bank remap and mask
        wr(16'h2000, 8'h00); rd(16'h4001);
        chk("R6", "bank 0 -> 1", 32'(rom_addr[20:14]), 32'd1);
        wr(16'h3FFF, 8'h80); rd(16'h7FFF);
        chk("R6", "bank 0x80 -> 1", 32'(rom_addr[20:14]), 32'd1);
        wr(16'h2ABC, 8'hC5); rd(16'h5555);
        chk("R6", "bank 0xC5 -> 0x45", 32'(rom_addr), {7'h45, 14'h1555});

        // R7: ram bank and dead range
        wr(16'h4000, 8'hFF); rd(16'hB234);
        chk("R7", "ram bank 3", 32'(xram_addr), {2'd3, 13'h1234});
        wr(16'h6000, 8'h00); wr(16'h7FFF, 8'h0A); rd(16'hB234);
        chk("R7", "0x6000 write ignored", 32'(xram_addr[14:13]), 32'd3);
        chk("R7", "0x7FFF write no enable", 32'(bus_rdata), 32'hFF);

        // R5 / R9: enable key
        wr(16'h0000, 8'h0A); rd(16'hA000);
        chk("R5", "enabled read passes", 32'(bus_rdata), 32'(8'hA0 ^ 8'h5A));
        wr(16'hA001, 8'h33);
        wr(16'h1FFF, 8'h0B); rd(16'hBFFF);
        chk("R5", "0x0B disables", 32'(bus_rdata), 32'hFF);
        wr(16'hA001, 8'h33);
        chk("R9", "no strobe while disabled", 32'(store_we), 32'd0);

        // R11 / R13 / R12
        rd(16'hFE9F); chk("R11", "oam vid addr", 32'(vid_addr), 32'h7E9F);
        rd(16'hFEA0); chk("R13", "0xFEA0 unmapped", 32'(bus_rdata), 32'h00);
        wr(16'hE123, 8'h77); chk("R13", "echo write quiet", 32'(store_we), 32'd0);
        wr(16'hFFFF, 8'h1F); rd(16'hFFFF);
        chk("R12", "ie readback", 32'(bus_rdata), 32'h1F);
        rd(16'hFF7F); chk("R11", "io index", 32'(io_idx), 32'h7F);
        rd(16'hFF80); chk("R10", "hram base", 32'(hram_addr), 32'd0);
        rd(16'hDFFF); chk("R10", "wram high", 32'(region), 32'd6);

        // Random mix, with the overlay switched off part way (R4)
        for (int i = 0; i < 600; i++) begin
            a = 16'($urandom);
            if ($urandom % 3 == 0) a = {3'($urandom % 3), 13'($urandom)};
            d = ($urandom % 4 == 0) ? 8'h0A : 8'($urandom);
            if (i == 300) begin
                cycle(16'h0000, 8'h00, 1'b0, 1'b1, 1'b0);
                rd(16'h0050);
                chk("R4", "overlay off", 32'(region), 32'd2);
            end
            cycle(a, d, 1'($urandom % 2), 1'b0, 1'b1);
        end
        rd(16'h0300); chk("R4", "overlay stays off", 32'(region), 32'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule